// File: doc/BRIEF.md
# RAM Increment Sweep Controller

This block is the master side of a small single-port synchronous RAM. A pulse on the start input makes it walk through every word of the RAM, from the lowest word address to the highest. At each word it reads the stored value, adds one and writes the sum back to the same location. A done pulse marks the end of the pass. The controller drives the RAM's address, write enable and write data, and it takes the RAM's read data back in. The RAM answers a read one clock after the address is presented.

Word addressing is used on the RAM side. A bus that looks at the same storage with byte addresses sees the words at offsets 0x0, 0x4, 0x8 and so on. The controller still steps its own word address by one. Each word takes four cycles: present the address, capture the returned data, write back, advance. A full pass over a 16-word RAM therefore keeps the controller busy for 64 cycles.

Top module: `ram_sweep_ctrl`

## Requirements
- R1: The cycle after a start is accepted in idle, busy is high. Busy stays high for exactly 4 x 16 = 64 consecutive cycles per pass.
- R2: The writes of one pass go to word addresses 0, 1, 2, ... 15 in ascending order, one apart. The step is by one word, not by four.
- R3: After a pass, every word holds its old value plus one modulo 2^32, so 0xFFFFFFFF becomes 0x00000000.
- R4: Write enable is high for exactly one cycle per address and never for two cycles in a row. A full pass has exactly 16 write cycles.
- R5: The write data equals the RAM read data of the same address, captured one cycle after the address was presented, plus one.
- R6: Done is a one-cycle pulse, exactly one per pass, in the cycle after the last busy cycle. Busy is low while done is high.
- R7: A start that arrives while busy is ignored. The pass is not restarted and is not lengthened, and no word is incremented twice.
- R8: rst_ni is an asynchronous active-low reset. While it is low, busy, done and write enable are low. When a pass is cut off by reset, the writes already made are kept. The next start begins again at address 0.
- R9: While idle with start low, write enable stays low and the RAM contents are unchanged.
- R10: A start held high in the cycle where done is high is accepted, and a new pass begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a pass when sampled high in idle |
| busy_o | output | 1 | High while a pass is in progress |
| done_o | output | 1 | One-cycle pulse after a pass completes |
| ram_addr_o | output | 4 | RAM word address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data, valid one cycle after the address |

## Verification
Some properties are checked by assertions on every cycle. Write enable is never high for two cycles running. The address only steps up by one or returns to zero. The write data always equals the previous cycle's read data plus one. Done never coincides with busy and always follows a write by two cycles, and a start seen while busy never moves the address backwards. Other behaviour needs the bench's scenarios. The final RAM contents, including the wrap of an all-ones word, come from those scenarios. So do the exact pass length and the place of the done pulse, and the back-to-back restart taken in the done cycle. The last of these is the outcome of a pass cut off by reset, with its partial writes kept and the next pass starting from address zero.

// File: rtl/ram_sweep_pkg.sv
package ram_sweep_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_CAPT  = 3'd2,
    S_WRITE = 3'd3,
    S_NEXT  = 3'd4
  } sweep_state_e;
endpackage

// File: rtl/sp_ram.sv
module sp_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // read-before-write, one cycle latency
  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[addr_i];
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/sweep_addr_cnt.sv
module sweep_addr_cnt #(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (step_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == LAST_ADDR);

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o != $past(addr_o)) |-> (addr_o == $past(addr_o) + 1'b1 || addr_o == '0));
endmodule

// File: rtl/sweep_incr.sv
module sweep_incr #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o
);
  logic [DATA_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sum_q <= '0;
    else if (capture_i) sum_q <= rdata_i + 1'b1; // wraps modulo 2^DATA_W
  end

  assign wdata_o = sum_q;

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && rdata_i == '1) |=> (wdata_o == '0));
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import ram_sweep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic busy_o,
  output logic done_o,
  output logic we_o,
  output logic capture_o,
  output logic step_o,
  output logic clr_o
);
  sweep_state_e state_q, state_d;
  logic         done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_READ;
      S_READ:  state_d = S_CAPT;
      S_CAPT:  state_d = S_WRITE;
      S_WRITE: state_d = S_NEXT;
      S_NEXT:  state_d = last_i ? S_IDLE : S_READ;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_NEXT) && last_i;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign we_o      = (state_q == S_WRITE);
  assign capture_o = (state_q == S_CAPT);
  assign step_o    = (state_q == S_NEXT) && !last_i;
  assign clr_o     = (state_q == S_IDLE) && start_i;

  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  assert_busy_on_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> !we_o);
endmodule

// File: rtl/ram_sweep_ctrl.sv
module ram_sweep_ctrl #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic last, capture, step, clr;

  sweep_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .last_i   (last),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .we_o     (ram_we_o),
    .capture_o(capture),
    .step_o   (step),
    .clr_o    (clr)
  );

  sweep_addr_cnt #(.DEPTH(DEPTH)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .step_i(step),
    .addr_o(ram_addr_o),
    .last_o(last)
  );

  sweep_incr #(.DATA_W(DATA_W)) u_incr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .rdata_i  (ram_rdata_i),
    .wdata_o  (ram_wdata_o)
  );

  // read data sampled one cycle before the write cycle
  assert_wdata_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_wdata_o == $past(ram_rdata_i) + 1'b1));
  assert_done_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ram_we_o, 2));
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (ram_addr_o >= $past(ram_addr_o)));
endmodule

// File: tb/ram_sweep_ctrl_tb.sv
module ram_sweep_ctrl_tb;
  localparam int DW = 32;
  localparam int N  = 16;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic          start = 1'b0;
  logic          busy, done, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] pre [N];
  logic [DW-1:0] expv[N];

  always #5 clk = ~clk;

  ram_sweep_ctrl #(.DATA_W(DW), .DEPTH(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .busy_o(busy), .done_o(done),
    .ram_addr_o(addr), .ram_we_o(we),
    .ram_wdata_o(wdata), .ram_rdata_i(rdata)
  );

  sp_ram #(.DATA_W(DW), .DEPTH(N)) u_ram (
    .clk_i(clk), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < N; i++)
      chk(u_ram.mem_q[i] === expv[i], req, $sformatf("word %0d", i), u_ram.mem_q[i], expv[i]);
  endtask

  // Caller stands at a negedge. Returns at the negedge where done is seen,
  // or right after reset is asserted when abort_at > 0.
  task automatic do_sweep(input bit poke, input int abort_at);
    int cyc = 0, busy_cyc = 0, we_cyc = 0, done_cnt = 0, done_at = 0;
    int addr_err = 0, data_err = 0, dbl = 0, done_busy = 0;
    logic prev_we = 1'b0;
    for (int i = 0; i < N; i++) pre[i] = u_ram.mem_q[i];
    start = 1'b1;
    while (1) begin
      @(negedge clk);
      cyc++;
      start = poke && (cyc == 20 || cyc == 64);
      if (cyc == 1) chk(busy === 1'b1, "R1/R10", "busy after start", {31'd0, busy}, 1);
      if (busy) busy_cyc++;
      if (we) begin
        if (addr !== AW'(we_cyc)) addr_err++;
        if (wdata !== pre[addr] + 1) data_err++;
        if (prev_we) dbl++;
        we_cyc++;
      end
      prev_we = we;
      if (abort_at > 0 && we_cyc == abort_at && cyc == 4 * abort_at + 2) begin
        rst_ni = 1'b0;
        #1;
        chk(busy === 1'b0 && done === 1'b0 && we === 1'b0, "R8", "outputs in reset",
            {29'd0, busy, done, we}, 0);
        start = 1'b0;
        return;
      end
      if (done) begin
        done_cnt++;
        done_at = cyc;
        if (busy) done_busy++;
        break;
      end
      if (cyc > 400) begin
        chk(1'b0, "R6", "sweep timeout", cyc, 4 * N + 1);
        break;
      end
    end
    start = 1'b0;
    chk(busy_cyc == 4 * N, "R1", "busy cycles", busy_cyc, 4 * N);
    chk(we_cyc == N, "R4", "write cycles", we_cyc, N);
    chk(dbl == 0, "R4", "back-to-back writes", dbl, 0);
    chk(addr_err == 0, "R2", "write address order errors", addr_err, 0);
    chk(data_err == 0, "R5", "write data errors", data_err, 0);
    chk(done_cnt == 1 && done_at == 4 * N + 1, "R6", "done position", done_at, 4 * N + 1);
    chk(done_busy == 0, "R6", "done with busy", done_busy, 0);
    for (int i = 0; i < N; i++) expv[i] = pre[i] + 1;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      u_ram.mem_q[i] = (32'(i) * 32'h1111_1111) ^ 32'hA5A5_0000;
    end
    u_ram.mem_q[0]  = 32'h0000_0000;
    u_ram.mem_q[8]  = 32'h7FFF_FFFF;
    u_ram.mem_q[15] = 32'hFFFF_FFFF;
    for (int i = 0; i < N; i++) expv[i] = u_ram.mem_q[i];

    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && we === 1'b0, "R8", "reset state",
        {29'd0, busy, done, we}, 0);
    rst_ni = 1'b1;

    // R9: idle, no activity
    begin
      int we_seen = 0;
      repeat (10) begin
        @(negedge clk);
        if (we) we_seen++;
      end
      chk(we_seen == 0, "R9", "write enable while idle", we_seen, 0);
      check_mem("R9");
    end

    // R1..R7: full sweep with starts poked mid-pass and in the last busy cycle
    @(negedge clk);
    do_sweep(1'b1, 0);
    check_mem("R3");
    chk(u_ram.mem_q[15] === 32'h0, "R3", "all-ones wraps", u_ram.mem_q[15], 0);
    chk(u_ram.mem_q[8] === 32'h8000_0000, "R3", "carry into msb", u_ram.mem_q[8], 32'h8000_0000);

    // R10: restart in the done cycle
    do_sweep(1'b0, 0);
    check_mem("R10");
    chk(u_ram.mem_q[15] === 32'h1, "R10", "second pass word 15", u_ram.mem_q[15], 1);

    // R8: cut off by reset after five writes
    @(negedge clk);
    do_sweep(1'b0, 5);
    for (int i = 0; i < N; i++) expv[i] = (i < 5) ? pre[i] + 1 : pre[i];
    repeat (2) @(negedge clk);
    check_mem("R8");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R8", "idle after reset release", {31'd0, busy}, 0);
    do_sweep(1'b0, 0);
    check_mem("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule